// File: doc/BRIEF.md
# Twin-Predicated Element Mover

This block is a sequencer that copies elements from a source vector to a destination vector. Both vectors live in one local register array. Each side has its own predicate mask and its own element counter. On every clock the sequencer finds the next enabled source element and the next enabled destination slot, then performs one register write. Because the two sides advance independently, common data-movement patterns need no opcodes of their own. Compress, expand, splat, extract, insert and an ordered multi-insert are all produced by the choice of masks and scalar flags.

A transfer starts with a single-cycle `start` pulse while the block is idle. The block captures the whole configuration at that edge: vector length, base registers, predicate sources, scalar flags, zeroing flags and twin or single mode. Elements then move at one per clock, and a one-cycle `done` pulse marks the end. A load port fills the array while the block is idle. A combinational read port lets the surrounding logic observe any register. The `wr_*` outputs show each destination write in the cycle in which it happens.

Top module: `twin_pred_mover`

## Requirements
- R1: After reset, `busy`, `done` and `wr_en` are all low.
- R2: When `start` is high while idle, the configuration is captured, and `busy` is high from the next cycle on. At most one destination write happens per active cycle, and no write happens while idle. A `start` seen while busy is ignored.
- R3: In twin mode (`twin`=1) with both sides vector and no zeroing, the k-th enabled source element (ascending order) is copied to the k-th enabled destination element. Moves stop when either side has no enabled element left below the vector length.
- R4: Predicate selection per side, with `*_psel` encoded as follows: 0 means all elements enabled; 1 means element i is enabled when bit i of `*_mask` is set; 2 means only the element whose index equals `*_bit` is enabled; 3 means all elements enabled.
- R5: With a scalar source and a vector destination, the value of register `src_base` is written to every enabled destination element (splat).
- R6: A scalar side always uses element 0 and ignores its mask. A scalar destination receives exactly one write, at register `dst_base`, and the transfer then ends.
- R7: With destination zeroing, each masked-out destination element that the destination counter reaches is written with zero, one element per clock. Without destination zeroing, masked-out destination elements receive no write and keep their value.
- R8: In twin mode with source zeroing, masked-out source elements are not skipped. Each one supplies the value zero to the next destination slot.
- R9: In single mode (`twin`=0), the destination uses the source predicate, the destination zeroing flag applies to both sides, and `src_zero` has no effect. When both sides are vector, the two counters stay equal.
- R10: `done` is high for exactly one cycle: the first active cycle in which either side has no element left, and that cycle has no write. `busy` is low on the following cycle. A vector length of 0 gives `done` on the first active cycle with no write. A length above VLMAX is treated as VLMAX.
- R11: Element i of a side is register (base + i) modulo the register count.
- R12: `ld_en` writes `ld_data` to `ld_addr` only while idle and is ignored while busy. `rd_data` shows the register at `rd_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load strobe for the register array (idle only) |
| ld_addr | input | 5 | Load register index |
| ld_data | input | 64 | Load value |
| rd_addr | input | 5 | Observation read index |
| rd_data | output | 64 | Observation read value |
| start | input | 1 | Begin a transfer (idle only) |
| vl | input | 6 | Vector length |
| twin | input | 1 | 1: independent predicates, 0: single predicate |
| src_base | input | 5 | First register of the source vector |
| dst_base | input | 5 | First register of the destination vector |
| src_psel | input | 2 | Source predicate selection |
| src_mask | input | 32 | Source explicit mask |
| src_bit | input | 5 | Source one-hot bit index |
| dst_psel | input | 2 | Destination predicate selection |
| dst_mask | input | 32 | Destination explicit mask |
| dst_bit | input | 5 | Destination one-hot bit index |
| src_scalar | input | 1 | Source is a single register |
| dst_scalar | input | 1 | Destination is a single register |
| src_zero | input | 1 | Source zeroing |
| dst_zero | input | 1 | Destination zeroing |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| wr_en | output | 1 | Destination write this cycle |
| wr_addr | output | 5 | Destination write register |
| wr_data | output | 64 | Destination write value |

## Verification
The properties assume that `start` and the configuration inputs only matter while idle. The bench pulses `start` at an idle moment, and it also pulses `start` deliberately in the middle of a transfer, which the properties tolerate. Lockstep counters are asserted only for single mode with both sides vector. The bench covers this case both with and without zeroing. The counter bounds rely on the length clamp. For that reason the stimulus includes lengths of 0, exactly VLMAX and above VLMAX, alongside random masks, bases that wrap and every predicate selection code.

// File: rtl/tpm_pkg.sv
// Shared types for the twin-predicated element mover.
// Assumes: predicate selection is carried as a 2-bit code.
package tpm_pkg;

    // Predicate source per side; the reserved code behaves as all-enabled.
    typedef enum logic [1:0] {
        PSEL_ALL    = 2'd0,
        PSEL_MASK   = 2'd1,
        PSEL_ONEHOT = 2'd2,
        PSEL_RSVD   = 2'd3
    } psel_e;

    // Sequencer state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

endpackage

// File: rtl/tpm_mask_gen.sv
// Expands a predicate selection into a per-element enable vector.
// Assumes: VLMAX >= 2; the one-hot index addresses elements 0..VLMAX-1.
module tpm_mask_gen
    import tpm_pkg::*;
#(
    parameter int VLMAX = 32,
    localparam int IW   = $clog2(VLMAX)
) (
    input  psel_e            sel,
    input  logic [VLMAX-1:0] mask,
    input  logic [IW-1:0]    bitidx,
    output logic [VLMAX-1:0] en
);

    // One enable per element, chosen by the selection code.
    for (genvar i = 0; i < VLMAX; i++) begin : g_bit
        assign en[i] = (sel == PSEL_MASK)   ? mask[i] :
                       (sel == PSEL_ONEHOT) ? (bitidx == IW'(i)) :
                                              1'b1;
    end

endmodule

// File: rtl/tpm_seek.sv
// Finds the lowest enabled element at or above a start index and below a limit.
// Assumes: limit <= VLMAX; found is low when no such element exists.
module tpm_seek #(
    parameter int VLMAX = 32,
    localparam int CW   = $clog2(VLMAX + 1)
) (
    input  logic [VLMAX-1:0] en,
    input  logic [CW-1:0]    from,
    input  logic [CW-1:0]    limit,
    output logic             found,
    output logic [CW-1:0]    idx
);

    // Descending scan so the last hit kept is the lowest qualifying index.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = VLMAX - 1; i >= 0; i--) begin
            if (en[i] && (CW'(i) >= from) && (CW'(i) < limit)) begin
                found = 1'b1;
                idx   = CW'(i);
            end
        end
    end

endmodule

// File: rtl/tpm_regfile.sv
// Local register array: one load write port, one mover write port,
// one mover read port and one observation read port.
// Assumes: the two write ports are never active together (load is idle-only);
// the mover port wins if they are.
module tpm_regfile #(
    parameter int NREG = 32,
    parameter int XLEN = 64,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            ld_we,
    input  logic [AW-1:0]   ld_addr,
    input  logic [XLEN-1:0] ld_data,
    input  logic            mv_we,
    input  logic [AW-1:0]   mv_addr,
    input  logic [XLEN-1:0] mv_data,
    input  logic [AW-1:0]   ra_addr,
    output logic [XLEN-1:0] ra_data,
    input  logic [AW-1:0]   rb_addr,
    output logic [XLEN-1:0] rb_data
);

    logic [XLEN-1:0] mem [NREG];

    // Write path: mover write has priority over the load port.
    always_ff @(posedge clk) begin
        if (mv_we) begin
            mem[mv_addr] <= mv_data;
        end else if (ld_we) begin
            mem[ld_addr] <= ld_data;
        end
    end

    // Combinational read ports.
    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];

endmodule

// File: rtl/twin_pred_mover.sv
// Twin-predicated element mover: steps independent source and destination
// element counters under their own predicates and performs one destination
// write (a move or a zero fill) per clock until either side runs out.
// Assumes: NREG is a power of two; VLMAX >= 2; configuration is sampled only
// with start while idle.
module twin_pred_mover
    import tpm_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int XLEN  = 64,
    parameter int VLMAX = 32,
    localparam int AW   = $clog2(NREG),
    localparam int IW   = $clog2(VLMAX),
    localparam int CW   = $clog2(VLMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [AW-1:0]    ld_addr,
    input  logic [XLEN-1:0]  ld_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [XLEN-1:0]  rd_data,
    input  logic             start,
    input  logic [CW-1:0]    vl,
    input  logic             twin,
    input  logic [AW-1:0]    src_base,
    input  logic [AW-1:0]    dst_base,
    input  logic [1:0]       src_psel,
    input  logic [VLMAX-1:0] src_mask,
    input  logic [IW-1:0]    src_bit,
    input  logic [1:0]       dst_psel,
    input  logic [VLMAX-1:0] dst_mask,
    input  logic [IW-1:0]    dst_bit,
    input  logic             src_scalar,
    input  logic             dst_scalar,
    input  logic             src_zero,
    input  logic             dst_zero,
    output logic             busy,
    output logic             done,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [XLEN-1:0]  wr_data
);

    // Captured configuration.
    state_e           state_q;
    logic [CW-1:0]    vl_q;
    logic             twin_q;
    logic [AW-1:0]    src_base_q, dst_base_q;
    psel_e            src_psel_q, dst_psel_q;
    logic [VLMAX-1:0] src_mask_q, dst_mask_q;
    logic [IW-1:0]    src_bit_q, dst_bit_q;
    logic             src_scalar_q, dst_scalar_q, src_zero_q, dst_zero_q;

    // Progress state.
    logic [CW-1:0]    si_q, di_q;
    logic             dwrote_q;

    // Derived per-cycle signals.
    logic [VLMAX-1:0] s_en, d_en_twin, d_en;
    logic             s_seek_ok, d_seek_ok;
    logic [CW-1:0]    s_seek_idx, d_seek_idx;
    logic             s_zmode;
    logic             s_ok, s_on, d_ok, d_on;
    logic [CW-1:0]    s_idx, d_idx;
    logic             active, finish, zfill, move;
    logic [AW-1:0]    src_raddr;
    logic [XLEN-1:0]  src_rdata;
    logic [CW-1:0]    vl_clamped;

    assign vl_clamped = (vl > CW'(VLMAX)) ? CW'(VLMAX) : vl;

    // Predicate expansion for each side.
    tpm_mask_gen #(.VLMAX(VLMAX)) u_smask (
        .sel(src_psel_q), .mask(src_mask_q), .bitidx(src_bit_q), .en(s_en)
    );
    tpm_mask_gen #(.VLMAX(VLMAX)) u_dmask (
        .sel(dst_psel_q), .mask(dst_mask_q), .bitidx(dst_bit_q), .en(d_en_twin)
    );
    assign d_en = twin_q ? d_en_twin : s_en;

    // Next enabled element search for each side.
    tpm_seek #(.VLMAX(VLMAX)) u_sseek (
        .en(s_en), .from(si_q), .limit(vl_q), .found(s_seek_ok), .idx(s_seek_idx)
    );
    tpm_seek #(.VLMAX(VLMAX)) u_dseek (
        .en(d_en), .from(di_q), .limit(vl_q), .found(d_seek_ok), .idx(d_seek_idx)
    );

    // Single mode shares the destination zeroing flag with the source side.
    assign s_zmode = twin_q ? src_zero_q : dst_zero_q;

    // Source element choice for this cycle.
    always_comb begin
        if (src_scalar_q) begin
            s_ok  = (vl_q != '0);
            s_idx = '0;
            s_on  = 1'b1;
        end else if (s_zmode) begin
            s_ok  = (si_q < vl_q);
            s_idx = si_q;
            s_on  = s_ok && s_en[si_q[IW-1:0]];
        end else begin
            s_ok  = s_seek_ok;
            s_idx = s_seek_idx;
            s_on  = 1'b1;
        end
    end

    // Destination element choice for this cycle.
    always_comb begin
        if (dst_scalar_q) begin
            d_ok  = (vl_q != '0) && !dwrote_q;
            d_idx = '0;
            d_on  = 1'b1;
        end else if (dst_zero_q) begin
            d_ok  = (di_q < vl_q);
            d_idx = di_q;
            d_on  = d_ok && d_en[di_q[IW-1:0]];
        end else begin
            d_ok  = d_seek_ok;
            d_idx = d_seek_idx;
            d_on  = 1'b1;
        end
    end

    // Action decode: finish, zero fill or element move.
    assign active = (state_q == ST_RUN);
    assign finish = active && !(s_ok && d_ok);
    assign zfill  = active && s_ok && d_ok && !d_on;
    assign move   = active && s_ok && d_ok && d_on;

    assign src_raddr = src_base_q + AW'(s_idx);

    // Register array with load, move and observation ports.
    tpm_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
        .clk     (clk),
        .ld_we   (ld_en && !active),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .mv_we   (wr_en),
        .mv_addr (wr_addr),
        .mv_data (wr_data),
        .ra_addr (src_raddr),
        .ra_data (src_rdata),
        .rb_addr (rd_addr),
        .rb_data (rd_data)
    );

    assign wr_en   = zfill || move;
    assign wr_addr = dst_base_q + AW'(d_idx);
    assign wr_data = (move && s_on) ? src_rdata : '0;
    assign busy    = active;
    assign done    = finish;

    // Sequencer state: capture on start, advance counters per action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            si_q     <= '0;
            di_q     <= '0;
            dwrote_q <= 1'b0;
        end else if (!active) begin
            if (start) begin
                state_q  <= ST_RUN;
                si_q     <= '0;
                di_q     <= '0;
                dwrote_q <= 1'b0;
            end
        end else if (finish) begin
            state_q <= ST_IDLE;
        end else if (zfill) begin
            di_q <= di_q + 1'b1;
            if (!twin_q && !src_scalar_q) begin
                si_q <= si_q + 1'b1;
            end
        end else begin
            si_q     <= src_scalar_q ? '0 : CW'(s_idx + 1'b1);
            di_q     <= dst_scalar_q ? '0 : CW'(d_idx + 1'b1);
            dwrote_q <= dst_scalar_q;
        end
    end

    // Configuration capture register, loaded only on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q         <= '0;
            twin_q       <= 1'b0;
            src_base_q   <= '0;
            dst_base_q   <= '0;
            src_psel_q   <= PSEL_ALL;
            dst_psel_q   <= PSEL_ALL;
            src_mask_q   <= '0;
            dst_mask_q   <= '0;
            src_bit_q    <= '0;
            dst_bit_q    <= '0;
            src_scalar_q <= 1'b0;
            dst_scalar_q <= 1'b0;
            src_zero_q   <= 1'b0;
            dst_zero_q   <= 1'b0;
        end else if (!active && start) begin
            vl_q         <= vl_clamped;
            twin_q       <= twin;
            src_base_q   <= src_base;
            dst_base_q   <= dst_base;
            src_psel_q   <= psel_e'(src_psel);
            dst_psel_q   <= psel_e'(dst_psel);
            src_mask_q   <= src_mask;
            dst_mask_q   <= dst_mask;
            src_bit_q    <= src_bit;
            dst_bit_q    <= dst_bit;
            src_scalar_q <= src_scalar;
            dst_scalar_q <= dst_scalar;
            src_zero_q   <= src_zero;
            dst_zero_q   <= dst_zero;
        end
    end

endmodule

// File: rtl/tpm_checker.sv
// Protocol and progress properties for the twin-predicated element mover.
// Assumes: bound to twin_pred_mover; sees its captured configuration and counters.
module tpm_checker #(
    parameter int CW = 6,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [CW-1:0] si,
    input logic [CW-1:0] di,
    input logic [CW-1:0] vl_q,
    input logic          twin_q,
    input logic          src_scalar_q,
    input logic          dst_scalar_q,
    input logic [AW-1:0] dst_base_q
);

    a_r10_done_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en);

    a_r10_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r2_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    a_r2_fresh_counters: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (si == '0) && (di == '0));

    a_r9_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !twin_q && !src_scalar_q && !dst_scalar_q) |-> (si == di));

    a_r6_scalar_dst_once: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dst_scalar_q) |=> !wr_en);

    a_r6_scalar_dst_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dst_scalar_q) |-> (wr_addr == dst_base_q));

    a_r10_counter_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (si <= vl_q) && (di <= vl_q));

endmodule

bind twin_pred_mover tpm_checker #(.CW(CW), .AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .si           (si_q),
    .di           (di_q),
    .vl_q         (vl_q),
    .twin_q       (twin_q),
    .src_scalar_q (src_scalar_q),
    .dst_scalar_q (dst_scalar_q),
    .dst_base_q   (dst_base_q)
);

// File: tb/tb_twin_pred_mover.sv
// Bench: behavioural reference model stepped at every falling edge, compared
// against all outputs each cycle.
module tb_twin_pred_mover;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [4:0]  ld_addr = '0;
    logic [63:0] ld_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic        start = 1'b0;
    logic [5:0]  vl = '0;
    logic        twin = 1'b0;
    logic [4:0]  src_base = '0, dst_base = '0;
    logic [1:0]  src_psel = '0, dst_psel = '0;
    logic [31:0] src_mask = '0, dst_mask = '0;
    logic [4:0]  src_bit = '0, dst_bit = '0;
    logic        src_scalar = 1'b0, dst_scalar = 1'b0;
    logic        src_zero = 1'b0, dst_zero = 1'b0;
    logic        busy, done, wr_en;
    logic [4:0]  wr_addr;
    logic [63:0] wr_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    twin_pred_mover dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .start(start), .vl(vl), .twin(twin),
        .src_base(src_base), .dst_base(dst_base), .src_psel(src_psel),
        .src_mask(src_mask), .src_bit(src_bit), .dst_psel(dst_psel),
        .dst_mask(dst_mask), .dst_bit(dst_bit), .src_scalar(src_scalar),
        .dst_scalar(dst_scalar), .src_zero(src_zero), .dst_zero(dst_zero),
        .busy(busy), .done(done), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // Reference model state.
    logic [63:0] m_rf [32];
    bit          m_init [32];
    bit          m_busy = 0;
    int          m_si, m_di;
    bit          m_dw;
    int          c_vl, c_sb, c_db, c_sps, c_dps, c_sbit, c_dbit;
    logic [31:0] c_smk, c_dmk;
    bit          c_twin, c_ssc, c_dsc, c_sz, c_dz;

    function automatic bit men(int ps, logic [31:0] mk, int b, int i);
        if (ps == 1) return mk[i];
        if (ps == 2) return (i == b);
        return 1'b1;
    endfunction

    function automatic int mseek(int ps, logic [31:0] mk, int b, int from, int lim);
        for (int i = from; i < lim; i++) begin
            if (men(ps, mk, b, i)) return i;
        end
        return -1;
    endfunction

    // Per-cycle comparison followed by the model step for the coming edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            m_busy = 0;
        end else begin
            bit e_done, e_we, sok, son, dok, don, szm;
            int sidx, didx, e_addr, dps_e, dbit_e;
            logic [31:0] dmk_e;
            logic [63:0] e_data;
            bit bad;
            e_done = 0; e_we = 0; e_addr = 0; e_data = '0;
            sok = 0; son = 0; dok = 0; don = 0; sidx = 0; didx = 0;
            if (m_busy) begin
                szm    = c_twin ? c_sz : c_dz;
                dps_e  = c_twin ? c_dps : c_sps;
                dmk_e  = c_twin ? c_dmk : c_smk;
                dbit_e = c_twin ? c_dbit : c_sbit;
                if (c_ssc) begin
                    sok = (c_vl != 0); sidx = 0; son = 1;
                end else if (szm) begin
                    sok = (m_si < c_vl); sidx = m_si;
                    son = sok && men(c_sps, c_smk, c_sbit, m_si);
                end else begin
                    sidx = mseek(c_sps, c_smk, c_sbit, m_si, c_vl);
                    sok = (sidx >= 0); son = 1;
                end
                if (c_dsc) begin
                    dok = (c_vl != 0) && !m_dw; didx = 0; don = 1;
                end else if (c_dz) begin
                    dok = (m_di < c_vl); didx = m_di;
                    don = dok && men(dps_e, dmk_e, dbit_e, m_di);
                end else begin
                    didx = mseek(dps_e, dmk_e, dbit_e, m_di, c_vl);
                    dok = (didx >= 0); don = 1;
                end
                if (!(sok && dok)) begin
                    e_done = 1;
                end else begin
                    e_we   = 1;
                    e_addr = (c_db + didx) % 32;
                    e_data = (don && son) ? m_rf[(c_sb + sidx) % 32] : 64'd0;
                end
            end
            // Compare every output this cycle.
            bad = (busy !== m_busy) || (done !== e_done) || (wr_en !== e_we);
            if (e_we && ((wr_addr !== 5'(e_addr)) || (wr_data !== e_data))) bad = 1;
            if (m_init[rd_addr] && (rd_data !== m_rf[rd_addr])) bad = 1;
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL %s t=%0t busy=%b/%b done=%b/%b wr_en=%b/%b addr=%0d/%0d data=%h/%h rd[%0d]=%h/%h",
                         cur_req, $time, busy, m_busy, done, e_done, wr_en, e_we,
                         wr_addr, e_addr, wr_data, e_data, rd_addr, rd_data, m_rf[rd_addr]);
            end
            // Model step.
            if (!m_busy) begin
                if (ld_en) begin
                    m_rf[ld_addr] = ld_data; m_init[ld_addr] = 1;
                end
                if (start) begin
                    m_busy = 1; m_si = 0; m_di = 0; m_dw = 0;
                    c_vl = (vl > 32) ? 32 : int'(vl);
                    c_twin = twin; c_sb = src_base; c_db = dst_base;
                    c_sps = src_psel; c_dps = dst_psel; c_smk = src_mask; c_dmk = dst_mask;
                    c_sbit = src_bit; c_dbit = dst_bit; c_ssc = src_scalar; c_dsc = dst_scalar;
                    c_sz = src_zero; c_dz = dst_zero;
                end
            end else if (e_done) begin
                m_busy = 0;
            end else begin
                m_rf[e_addr] = e_data; m_init[e_addr] = 1;
                if (!don) begin
                    m_di++;
                    if (!c_twin && !c_ssc) m_si++;
                end else begin
                    m_si = c_ssc ? 0 : sidx + 1;
                    m_di = c_dsc ? 0 : didx + 1;
                    m_dw = c_dsc;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #5;
    endtask

    task automatic load_all(input logic [31:0] seed);
        cur_req = "R12";
        for (int i = 0; i < 32; i++) begin
            ld_en = 1; ld_addr = 5'(i); ld_data = {seed + 32'(i), 32'hC0DE_0000 | 32'(i * 7)};
            step();
        end
        ld_en = 0;
    endtask

    task automatic sweep();
        for (int i = 0; i < 32; i++) begin
            rd_addr = 5'(i); step();
        end
    endtask

    task automatic run_op(input string req, input bit tw, input int sb, input int db,
                          input int sps, input logic [31:0] smk, input int sbt,
                          input int dps, input logic [31:0] dmk, input int dbt,
                          input bit ssc, input bit dsc, input bit szr, input bit dzr,
                          input int vlen, input bit poke);
        cur_req = req;
        twin = tw; src_base = 5'(sb); dst_base = 5'(db);
        src_psel = 2'(sps); src_mask = smk; src_bit = 5'(sbt);
        dst_psel = 2'(dps); dst_mask = dmk; dst_bit = 5'(dbt);
        src_scalar = ssc; dst_scalar = dsc; src_zero = szr; dst_zero = dzr;
        vl = 6'(vlen); start = 1;
        step();
        start = 0;
        if (poke) begin
            step(); step();
            // R2 / R12: start and load while busy must have no effect.
            start = 1; ld_en = 1; ld_addr = 5'(db); ld_data = 64'hDEAD_BEEF_0BAD_F00D;
            vl = 6'd3; twin = 0;
            step();
            start = 0; ld_en = 0;
        end
        while (busy) step();
        step();
        sweep();
    endtask

    initial begin
        for (int i = 0; i < 32; i++) m_init[i] = 0;
        repeat (3) @(posedge clk);
        #5 rst_n = 1;
        cur_req = "R1";
        step(); step();
        load_all(32'h1000_0000);
        // R3/R4: compress then expand with explicit masks.
        run_op("R3", 1, 0, 16, 1, 32'h0000_00B6, 0, 1, 32'h0000_0F0F, 0, 0, 0, 0, 0, 16, 0);
        // R4: one-hot source, scalar destination (extract).
        run_op("R4", 1, 8, 3, 2, 32'h0, 5, 0, 32'h0, 0, 0, 1, 0, 0, 12, 0);
        // R6: scalar destination with all-enabled source moves only element 0.
        run_op("R6", 1, 4, 30, 3, 32'h0, 0, 1, 32'h0, 0, 0, 1, 0, 0, 20, 0);
        // R5: splat scalar source over masked destination.
        run_op("R5", 1, 2, 10, 0, 32'h0, 0, 1, 32'h0000_5A5A, 0, 1, 0, 0, 0, 16, 0);
        // R4: one-hot destination insert from scalar source.
        run_op("R4", 1, 1, 20, 0, 32'h0, 0, 2, 32'h0, 7, 1, 0, 0, 0, 10, 0);
        load_all(32'h2000_0000);
        // R7: destination zeroing versus no zeroing.
        run_op("R7", 1, 0, 16, 1, 32'h0000_0033, 0, 1, 32'h0000_0249, 0, 0, 0, 0, 1, 12, 0);
        run_op("R7", 1, 0, 16, 1, 32'h0000_0033, 0, 1, 32'h0000_0249, 0, 0, 0, 0, 0, 12, 0);
        // R8: source zeroing supplies zeros for masked sources.
        run_op("R8", 1, 3, 12, 1, 32'h0000_0055, 0, 0, 32'h0, 0, 0, 0, 1, 0, 8, 0);
        // R9: single mode, with and without zeroing; src_zero ignored.
        run_op("R9", 0, 0, 8, 1, 32'h0000_9C3A, 0, 1, 32'hFFFF_FFFF, 0, 0, 0, 1, 0, 16, 0);
        run_op("R9", 0, 0, 8, 1, 32'h0000_9C3A, 0, 0, 32'h0, 0, 0, 0, 0, 1, 16, 0);
        load_all(32'h3000_0000);
        // R10: zero length, full length, over-long length.
        run_op("R10", 1, 0, 1, 0, 32'h0, 0, 0, 32'h0, 0, 0, 0, 0, 0, 0, 0);
        run_op("R10", 1, 0, 0, 0, 32'h0, 0, 0, 32'h0, 0, 0, 0, 0, 0, 32, 0);
        run_op("R10", 1, 0, 0, 1, 32'h8000_0001, 0, 0, 32'h0, 0, 0, 0, 0, 1, 40, 0);
        // R11: bases that wrap around the array.
        run_op("R11", 1, 28, 25, 0, 32'h0, 0, 0, 32'h0, 0, 0, 0, 0, 0, 10, 0);
        // R2/R12: start and load pulsed mid-transfer.
        run_op("R2", 1, 0, 16, 0, 32'h0, 0, 0, 32'h0, 0, 0, 0, 0, 0, 16, 1);
        // R3: pseudo-random configurations.
        for (int k = 0; k < 24; k++) begin
            if (k % 6 == 0) load_all($urandom);
            run_op("R3", 1'($urandom), int'($urandom % 32), int'($urandom % 32),
                   int'($urandom % 4), $urandom, int'($urandom % 32),
                   int'($urandom % 4), $urandom, int'($urandom % 32),
                   1'($urandom % 4 == 0), 1'($urandom % 4 == 0),
                   1'($urandom), 1'($urandom), int'($urandom % 34), 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule